// File: doc/BRIEF.md
# Cycle-Stealing DMA Block Transfer Controller

This controller moves a block of words between one selected peripheral data port and memory without the processor handling each word. Software programs a transfer direction, a device number, a starting memory address and a word count through a small register port, then sets a start bit. From that point the controller works alone until the block is done.

The transfer uses strict cycle stealing. The controller asks for the system bus only when the selected device can supply or accept a word. It moves exactly one word in the cycle that holds the grant, then drops its request for at least one cycle so the processor gets the bus back. It repeats this until the count is used up. It then leaves the busy state and raises an interrupt line. The line stays high until software clears it. A block of zero words finishes at once: the interrupt is raised and the bus is never requested.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, bus_req, mem_we, mem_re and irq are low, and the status word (register select 3) reads zero.
- R2: Register select 1 holds the start address and select 2 holds the word count. Select 0 holds the direction at bit 1 (1 = memory to device, 0 = device to memory) and the device number at bits [2 +: DSW]. All three read back what was written while idle, and dev_sel is the one-hot decode of the device number.
- R3: In device-to-memory mode, each word moves with mem_we high for one cycle. mem_wdata carries dev_rdata, dev_ack is high, and mem_re stays low.
- R4: In memory-to-device mode, each word moves with mem_re high for one cycle. dev_wdata carries mem_rdata in that same cycle, dev_ack is high, and mem_we stays low.
- R5: bus_req is high only while busy and while the selected device's ready bit is high; other devices' ready bits have no effect. A word moves only in a cycle where both bus_req and bus_gnt are high.
- R6: In the cycle after any word moves, bus_req is low, even if the grant stays high.
- R7: Each word goes to the current address. After each word the address goes up by one and the count goes down by one, so the address reads start+N at the end.
- R8: In the cycle after the last word, busy (status bit 0) is low and irq (status bit 1) is high.
- R9: Writes to select 0, 1 and 2 while busy have no effect, including a second start.
- R10: Once raised, irq stays high until a status write with bit 1 set. A status write with only bit 0 set leaves it high.
- R11: Starting with a count of zero raises irq in the next cycle. busy stays low and bus_req is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 count, 3 status |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data for reg_sel (combinational) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data read from memory, valid in the same cycle as mem_re |
| dev_sel | output | DEV_N | One-hot device select |
| dev_rdy | input | DEV_N | Per-device ready bits |
| dev_rdata | input | DW | Word offered by the device |
| dev_wdata | output | DW | Word delivered to the device |
| dev_ack | output | 1 | Word taken from or given to the device this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the grant is given only to a cycle that carries a request. They also assume that memory read data is valid in the same cycle as mem_re, and that a device's ready bit does not depend on dev_ack in the same cycle. The bench's arbiter model forms the grant as the request ANDed with a permit pattern, and it returns memory data combinationally from the address. Its device model changes its offered word only on the clock edge that follows an acknowledge. Ready and permit patterns are derived from a cycle counter that changes at the clock edge, so every sample taken at the falling edge sees settled values.

// File: rtl/dma_steal_pkg.sv
`timescale 1ns/1ps
package dma_steal_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } seq_state_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DIR_BIT   = 1;
  localparam int CTRL_DEV_LSB   = 2;
  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_IRQ_BIT   = 1;
endpackage

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
  import dma_steal_pkg::*;
#(
  parameter int RW  = 32,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_sel,
  input  logic [RW-1:0]  reg_wdata,
  input  logic           busy,
  input  logic           irq,
  input  logic [AW-1:0]  cur_addr,
  input  logic [CW-1:0]  cur_count,
  output logic [RW-1:0]  reg_rdata,
  output logic           dir,
  output logic [DSW-1:0] dev,
  output logic           start_ev,
  output logic           addr_ld,
  output logic           cnt_ld,
  output logic           irq_clr
);
  reg_sel_e sel_e;
  logic     wr_idle;
  logic     ctrl_ld;

  assign sel_e    = reg_sel_e'(reg_sel);
  assign wr_idle  = reg_wr && !busy;
  assign ctrl_ld  = wr_idle && (sel_e == SEL_CTRL);
  assign start_ev = ctrl_ld && reg_wdata[CTRL_START_BIT];
  assign addr_ld  = wr_idle && (sel_e == SEL_ADDR);
  assign cnt_ld   = wr_idle && (sel_e == SEL_CNT);
  assign irq_clr  = reg_wr && (sel_e == SEL_STAT) && reg_wdata[STAT_IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= 1'b0;
      dev <= '0;
    end else if (ctrl_ld) begin
      dir <= reg_wdata[CTRL_DIR_BIT];
      dev <= reg_wdata[CTRL_DEV_LSB +: DSW];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel_e)
      SEL_CTRL: begin
        reg_rdata[CTRL_DIR_BIT]           = dir;
        reg_rdata[CTRL_DEV_LSB +: DSW]    = dev;
      end
      SEL_ADDR: reg_rdata = RW'(cur_addr);
      SEL_CNT:  reg_rdata = RW'(cur_count);
      default: begin
        reg_rdata[STAT_BUSY_BIT] = busy;
        reg_rdata[STAT_IRQ_BIT]  = irq;
      end
    endcase
  end
endmodule

// File: rtl/dma_xfer_ctr.sv
`timescale 1ns/1ps
module dma_xfer_ctr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic          cnt_ld,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic          last,
  output logic          zero
);
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] count_after(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr_after(addr);
    end else if (addr_ld) begin
      addr <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= count_after(count);
    end else if (cnt_ld) begin
      count <= cnt_in;
    end
  end

  assign last = (count == CW'(1));
  assign zero = (count == '0);
endmodule

// File: rtl/dma_steal_seq.sv
`timescale 1ns/1ps
module dma_steal_seq
  import dma_steal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic zero,
  input  logic last,
  input  logic sel_rdy,
  input  logic bus_gnt,
  input  logic irq_clr,
  output logic busy,
  output logic irq,
  output logic bus_req,
  output logic xfer
);
  seq_state_e state;
  logic       gap;
  logic       finish;
  logic       empty_start;

  assign busy        = (state == ST_ACTIVE);
  assign bus_req     = busy && sel_rdy && !gap;
  assign xfer        = bus_req && bus_gnt;
  assign finish      = xfer && last;
  assign empty_start = start_ev && zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (start_ev && !zero) state <= ST_ACTIVE;
        ST_ACTIVE: if (finish) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 1'b0;
    else        gap <= xfer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (finish || empty_start)  irq <= 1'b1;
    else if (irq_clr)                irq <= 1'b0;
  end
endmodule

// File: rtl/dma_steal_ctrl.sv
`timescale 1ns/1ps
module dma_steal_ctrl #(
  parameter int RW    = 32,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int DEV_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic             mem_re,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DEV_N-1:0] dev_sel,
  input  logic [DEV_N-1:0] dev_rdy,
  input  logic [DW-1:0]    dev_rdata,
  output logic [DW-1:0]    dev_wdata,
  output logic             dev_ack,
  output logic             irq
);
  localparam int DSW = (DEV_N > 1) ? $clog2(DEV_N) : 1;

  logic           busy_w;
  logic           dir_w;
  logic [DSW-1:0] dev_w;
  logic           start_w;
  logic           addr_ld_w;
  logic           cnt_ld_w;
  logic           irq_clr_w;
  logic [CW-1:0]  count_w;
  logic           last_w;
  logic           zero_w;
  logic           sel_rdy_w;
  logic           xfer_w;

  dma_cfg_regs #(.RW(RW), .AW(AW), .CW(CW), .DSW(DSW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .busy      (busy_w),
    .irq       (irq),
    .cur_addr  (mem_addr),
    .cur_count (count_w),
    .reg_rdata (reg_rdata),
    .dir       (dir_w),
    .dev       (dev_w),
    .start_ev  (start_w),
    .addr_ld   (addr_ld_w),
    .cnt_ld    (cnt_ld_w),
    .irq_clr   (irq_clr_w)
  );

  dma_xfer_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_ld (addr_ld_w),
    .cnt_ld  (cnt_ld_w),
    .addr_in (reg_wdata[AW-1:0]),
    .cnt_in  (reg_wdata[CW-1:0]),
    .step    (xfer_w),
    .addr    (mem_addr),
    .count   (count_w),
    .last    (last_w),
    .zero    (zero_w)
  );

  dma_steal_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_w),
    .zero     (zero_w),
    .last     (last_w),
    .sel_rdy  (sel_rdy_w),
    .bus_gnt  (bus_gnt),
    .irq_clr  (irq_clr_w),
    .busy     (busy_w),
    .irq      (irq),
    .bus_req  (bus_req),
    .xfer     (xfer_w)
  );

  for (genvar g = 0; g < DEV_N; g++) begin : g_devsel
    assign dev_sel[g] = (dev_w == DSW'(g));
  end

  assign sel_rdy_w = |(dev_rdy & dev_sel);
  assign mem_we    = xfer_w && !dir_w;
  assign mem_re    = xfer_w && dir_w;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign dev_ack   = xfer_w;
endmodule

// File: rtl/dma_steal_chk.sv
`timescale 1ns/1ps
module dma_steal_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          busy,
  input logic          last,
  input logic          irq_clr
);
  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R5
  word_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (bus_gnt && bus_req));

  // R5
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  // R6
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !bus_req);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> (mem_addr == $past(mem_addr) + AW'(1)));

  // R8
  block_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && last) |=> (irq && !busy));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind dma_steal_ctrl dma_steal_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .irq      (irq),
  .busy     (busy_w),
  .last     (last_w),
  .irq_clr  (irq_clr_w)
);

// File: tb/sim_dma_steal_ctrl.sv
`timescale 1ns/1ps
module sim_dma_steal_ctrl;
  localparam int RW = 32, AW = 16, CW = 16, DW = 16, DEV_N = 4;
  localparam logic [DW-1:0] DATA_BASE = 16'hC000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             reg_wr;
  logic [1:0]       reg_sel;
  logic [RW-1:0]    reg_wdata;
  logic [RW-1:0]    reg_rdata;
  logic             bus_req, bus_gnt;
  logic [AW-1:0]    mem_addr;
  logic             mem_we, mem_re;
  logic [DW-1:0]    mem_wdata, mem_rdata;
  logic [DEV_N-1:0] dev_sel, dev_rdy;
  logic [DW-1:0]    dev_rdata, dev_wdata;
  logic             dev_ack, irq;

  dma_steal_ctrl #(.RW(RW), .AW(AW), .CW(CW), .DW(DW), .DEV_N(DEV_N)) u0 (.*);

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int gnt_mode = 0, rdy_mode = 0;
  int cur_dev = 0;
  logic rdy_en = 1'b0, other_rdy = 1'b0;
  logic [DW-1:0] taken = '0;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return DW'(a) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dev_ack) taken <= taken + 1'b1;
  end

  logic gnt_ok, rdy_pat;
  assign gnt_ok  = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? cyc[0] : ((cyc % 3) == 0);
  assign rdy_pat = (rdy_mode == 0) ? 1'b1 : (cyc[2:1] != 2'b00);
  assign bus_gnt = bus_req && gnt_ok;
  always_comb begin
    dev_rdy = {DEV_N{other_rdy}};
    dev_rdy[cur_dev] = rdy_en && rdy_pat;
  end
  assign mem_rdata = mem_fn(mem_addr);
  assign dev_rdata = DATA_BASE + taken;

  typedef struct {
    logic          dir;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;
  item_t expq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as words move
  bit prev_xfer = 0, done_pending = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pending) begin
        chk(irq == 1'b1, "R8 irq after last word", 32'(irq), 32'd1);
        chk(u0.reg_rdata[0] == 1'b0 || reg_sel != 2'd3, "R8 busy low after last word", 32'(reg_rdata), 32'd2);
        done_pending = 0;
      end
      if (prev_xfer) chk(!bus_req, "R6 request dropped after word", 32'(bus_req), 32'd0);
      if (bus_req) chk(dev_rdy[cur_dev], "R5 request without ready", 32'(dev_rdy), 32'(1 << cur_dev));
      prev_xfer = mem_we || mem_re;
      if (mem_we || mem_re) begin
        chk(bus_gnt, "R5 word without grant", 32'(bus_gnt), 32'd1);
        chk(dev_ack, "R3 R4 dev_ack with word", 32'(dev_ack), 32'd1);
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected word", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          item_t it;
          it = expq.pop_front();
          chk(mem_addr == it.a, "R7 word address", 32'(mem_addr), 32'(it.a));
          if (it.dir) begin
            chk(mem_re && !mem_we, "R4 read strobe only", {30'd0, mem_we, mem_re}, 32'd1);
            chk(dev_wdata == it.d, "R4 word to device", 32'(dev_wdata), 32'(it.d));
          end else begin
            chk(mem_we && !mem_re, "R3 write strobe only", {30'd0, mem_we, mem_re}, 32'd2);
            chk(mem_wdata == it.d, "R3 word to memory", 32'(mem_wdata), 32'(it.d));
          end
          if (expq.size() == 0) done_pending = 1;
        end
      end
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [RW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [RW-1:0] d);
    @(posedge clk); #1;
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic program_start(input bit dir, input int dev, input logic [AW-1:0] a, input int n);
    reg_write(2'd1, RW'(a));
    reg_write(2'd2, RW'(n));
    cur_dev = dev;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.dir = dir;
      it.a   = a + AW'(i);
      it.d   = dir ? mem_fn(a + AW'(i)) : DATA_BASE + taken + DW'(i);
      expq.push_back(it);
    end
    reg_write(2'd0, RW'((dev << 2) | (int'(dir) << 1) | 1));
  endtask

  task automatic wait_done(input string tag);
    logic [RW-1:0] st;
    int guard = 0;
    do begin
      reg_read(2'd3, st);
      guard++;
    end while (st[0] && guard < 2000);
    chk(!st[0], tag, st, 32'd2);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R7 all words moved", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !mem_we && !mem_re && !irq, "R1 outputs after reset",
        {28'd0, bus_req, mem_we, mem_re, irq}, 32'd0);
    chk(reg_rdata == '0, "R1 status after reset", reg_rdata, 32'd0);

    // R2 readback while idle
    reg_write(2'd1, 32'h0000_1234);
    reg_write(2'd2, 32'h0000_0021);
    reg_write(2'd0, 32'h0000_000A);
    reg_read(2'd1, v); chk(v == 32'h1234, "R2 address readback", v, 32'h1234);
    reg_read(2'd2, v); chk(v == 32'h21, "R2 count readback", v, 32'h21);
    reg_read(2'd0, v); chk(v == 32'hA, "R2 control readback", v, 32'hA);
    chk(dev_sel == 4'b0100, "R2 one-hot device select", 32'(dev_sel), 32'h4);

    // R5 no request while idle even with ready
    rdy_en = 1'b1; other_rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req, "R5 idle no request", 32'(bus_req), 32'd0);

    // R3 device to memory, grant held high
    gnt_mode = 0; rdy_mode = 0;
    program_start(1'b0, 2, 16'h0100, 5);
    wait_done("R8 run1 busy clears");
    reg_read(2'd1, v); chk(v == 32'h0105, "R7 final address", v, 32'h0105);
    reg_read(2'd2, v); chk(v == 32'h0, "R7 final count", v, 32'h0);

    // R10 irq holds, bit0-only write does not clear
    repeat (5) @(negedge clk);
    chk(irq, "R10 irq held", 32'(irq), 32'd1);
    reg_write(2'd3, 32'h1);
    @(negedge clk);
    chk(irq, "R10 irq kept by bit0 write", 32'(irq), 32'd1);
    reg_write(2'd3, 32'h2);
    @(negedge clk);
    chk(!irq, "R10 irq cleared", 32'(irq), 32'd0);

    // R4 memory to device, intermittent grant
    gnt_mode = 1;
    program_start(1'b1, 1, 16'h0200, 4);
    wait_done("R8 run2 busy clears");
    reg_write(2'd3, 32'h2);

    // R9 writes ignored while busy; R5 other devices' ready ignored
    gnt_mode = 2; rdy_mode = 1;
    program_start(1'b0, 3, 16'h0300, 6);
    rdy_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(!bus_req, "R5 other ready ignored", 32'(bus_req), 32'd0);
    reg_write(2'd1, 32'h0BAD);
    reg_write(2'd2, 32'h0007);
    reg_write(2'd0, 32'h0000_0003);
    reg_read(2'd0, v); chk(v == 32'h0000_000C, "R9 control unchanged", v, 32'hC);
    reg_read(2'd2, v); chk(v == 32'h6, "R9 count unchanged", v, 32'h6);
    rdy_en = 1'b1;
    wait_done("R8 run3 busy clears");
    reg_read(2'd1, v); chk(v == 32'h0306, "R9 address unaffected", v, 32'h0306);
    reg_write(2'd3, 32'h2);

    // R11 zero count
    rdy_mode = 0;
    @(negedge clk);
    chk(!irq, "R11 irq low before", 32'(irq), 32'd0);
    reg_write(2'd2, 32'h0);
    reg_write(2'd0, 32'h0000_0009);
    @(negedge clk);
    chk(irq, "R11 irq at once", 32'(irq), 32'd1);
    reg_read(2'd3, v); chk(v == 32'h2, "R11 busy stays low", v, 32'h2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!bus_req, "R11 no request", 32'(bus_req), 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule